// File: doc/BRIEF.md
# Flash Write-Command Sequence Decoder

This block sits between the host write strobes of a parallel flash device and the array control logic. It watches every write cycle (a falling write-enable edge while the chip is selected and the output driver is off) and recognises the unlock-guarded command sequences. A complete program sequence yields a one-cycle program request carrying the word address and data. A complete erase sequence yields a one-cycle erase request with a kind (sector, block or whole chip) and an aligned base address.

A malformed write anywhere inside a sequence drops the decoder back to read mode. A write-protect pin, sampled at the first unlock write, refuses any change to the top 8K-word region. Erase suspend and resume are single-write commands that are honoured only when an erase is running or parked. The array reports the end of an erase through `erase_done`. Reset ends everything, and an erase cut short by reset is not resumed.

Top module: `flash_cmd_decoder`

## Requirements
- R1: Word 0x00AA at an address whose bits [14:0] are 0x5555, then 0x55 at 0x2AAA, then 0xA0 at 0x5555, then any address/data write, gives `pgm_req` high for one cycle. `pgm_addr` and `pgm_data` are equal to the fourth write's address and data. The request appears three clock cycles after the fourth falling write edge.
- R2: Six writes (0xAA@0x5555, 0x55@0x2AAA, 0x80@0x5555, 0xAA@0x5555, 0x55@0x2AAA, final) give `ers_req`, and `erase_active` then goes high. A final byte of 0x30 is a sector erase: `ers_kind`=1 and the address is cleared in bits [10:0]. A final 0x50 is a block erase: kind 2, with bits [14:0] cleared. A final 0x10 at 0x5555 is a chip erase: kind 3, address 0.
- R3: Any write that does not fit the expected step returns the decoder to read mode. The remaining writes of that broken sequence produce no request, and a new sequence must start again at 0xAA.
- R4: When `wp_n` is low at the first unlock write, the following are refused: a program whose address has bits [19:13] all ones, a sector erase in that region, a block erase whose bits [19:15] are all ones, and any chip erase. Changing `wp_n` after the first unlock write has no effect on that sequence. Programs outside the region are still granted.
- R5: A write cycle counts only on a falling edge of `we_n` with `ce_n` low and `oe_n` high. An inhibited strobe is ignored and does not break a sequence in progress. Holding `we_n` low counts as one write.
- R6: With `rst_n` low, all requests are held low and the sequence, `erase_active` and `erase_suspended` are cleared. After reset a resume command (0x30) has no effect.
- R7: A single write of 0xB0 suspends an erase only while `erase_active` is high and `erase_suspended` is low: it gives `susp_req` and sets `erase_suspended`. A single write of 0x30 resumes only while suspended: it gives `resume_req` and clears `erase_suspended`.
- R8: While an erase runs and is not suspended, neither program nor erase sequences are granted. While the erase is suspended, programs are granted and erases are not.
- R9: An `erase_done` pulse clears `erase_active` and `erase_suspended`.
- R10: At most one of the four request outputs is high in a cycle, and each request lasts exactly one cycle.
- R11: Unlock and command address checks use only address bits [14:0]. Command bytes are taken from data bits [7:0].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Decoder clock |
| rst_n | input | 1 | Active-low synchronous reset |
| we_n | input | 1 | Host write enable, asynchronous |
| ce_n | input | 1 | Host chip enable, asynchronous |
| oe_n | input | 1 | Host output enable, asynchronous |
| wp_n | input | 1 | Write-protect pin, low protects the top region |
| addr | input | ADDR_W (20) | Word address of the write |
| wdata | input | DATA_W (16) | Write data |
| erase_done | input | 1 | Pulse from the array when an erase ends |
| pgm_req | output | 1 | One-cycle program request |
| pgm_addr | output | ADDR_W | Program target address |
| pgm_data | output | DATA_W | Program data word |
| ers_req | output | 1 | One-cycle erase request |
| ers_kind | output | 2 | 1 sector, 2 block, 3 chip |
| ers_addr | output | ADDR_W | Aligned erase base address |
| susp_req | output | 1 | One-cycle erase-suspend request |
| resume_req | output | 1 | One-cycle erase-resume request |
| erase_active | output | 1 | An erase has been issued and not finished |
| erase_suspended | output | 1 | The active erase is parked |

## Verification
On every cycle the assertions check the following: each request follows a recognised write strobe, requests are mutually exclusive, a latched protect level never lets a protected program or a chip erase through, no erase is granted over a running one, and a suspend is granted only against a running, unparked erase. Whether a given sequence is accepted or dropped can be shown only by the bench scenarios. These cover the exact unlock order, aborts at each step, inhibited and stretched strobes, upper address bits being ignored, protect timing, and reset in the middle of an erase.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;

  localparam logic [7:0]  CMD_KEY1   = 8'hAA;
  localparam logic [7:0]  CMD_KEY2   = 8'h55;
  localparam logic [7:0]  CMD_WRITE  = 8'hA0;
  localparam logic [7:0]  CMD_WIPE   = 8'h80;
  localparam logic [7:0]  CMD_SECTOR = 8'h30;
  localparam logic [7:0]  CMD_BLOCK  = 8'h50;
  localparam logic [7:0]  CMD_CHIP   = 8'h10;
  localparam logic [7:0]  CMD_PAUSE  = 8'hB0;
  localparam logic [7:0]  CMD_RESUME = 8'h30;

  localparam logic [14:0] LOC_KEY1 = 15'h5555;
  localparam logic [14:0] LOC_KEY2 = 15'h2AAA;

  typedef enum logic [2:0] {
    ST_READ, ST_K1, ST_K2, ST_PGM_ARG, ST_W1, ST_W2, ST_W3
  } seq_state_t;

  typedef enum logic [1:0] {
    EK_NONE = 2'd0, EK_SECT = 2'd1, EK_BLK = 2'd2, EK_CHIP = 2'd3
  } ekind_t;

  function automatic logic step_match(input logic [14:0] a, input logic [7:0] d,
                                      input logic [14:0] ea, input logic [7:0] ed);
    return (a == ea) && (d == ed);
  endfunction

endpackage

// File: rtl/fsc_sync.sv
module fsc_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic we_n,
  input  logic ce_n,
  input  logic oe_n,
  output logic wr_evt
);
  logic [STAGES-1:0] we_sh, ce_sh, oe_sh;
  logic              we_prev;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      we_sh   <= '1;
      ce_sh   <= '1;
      oe_sh   <= '1;
      we_prev <= 1'b1;
    end else begin
      we_sh   <= {we_sh[STAGES-2:0], we_n};
      ce_sh   <= {ce_sh[STAGES-2:0], ce_n};
      oe_sh   <= {oe_sh[STAGES-2:0], oe_n};
      we_prev <= we_sh[STAGES-1];
    end
  end

  // one event per falling strobe, only when selected and not reading
  assign wr_evt = we_prev & ~we_sh[STAGES-1] & ~ce_sh[STAGES-1] & oe_sh[STAGES-1];
endmodule

// File: rtl/fsc_seq.sv
module fsc_seq
  import flash_cmd_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_evt,
  input  logic [14:0] addr_lo,
  input  logic [7:0]  cmd,
  input  logic        wp_n,
  output logic        pgm_hit,
  output logic        ers_hit,
  output ekind_t      hit_kind,
  output logic        susp_hit,
  output logic        res_hit,
  output logic        wp_lock
);
  seq_state_t state, nxt;
  logic       key1_now;

  assign key1_now = step_match(addr_lo, cmd, LOC_KEY1, CMD_KEY1);

  always_comb begin
    nxt      = state;
    pgm_hit  = 1'b0;
    ers_hit  = 1'b0;
    susp_hit = 1'b0;
    res_hit  = 1'b0;
    hit_kind = EK_NONE;
    if (wr_evt) begin
      nxt = ST_READ;
      unique case (state)
        ST_READ: begin
          if (cmd == CMD_PAUSE)       susp_hit = 1'b1;
          else if (cmd == CMD_RESUME) res_hit  = 1'b1;
          else if (key1_now)          nxt      = ST_K1;
        end
        ST_K1: if (step_match(addr_lo, cmd, LOC_KEY2, CMD_KEY2)) nxt = ST_K2;
        ST_K2: begin
          if (step_match(addr_lo, cmd, LOC_KEY1, CMD_WRITE))     nxt = ST_PGM_ARG;
          else if (step_match(addr_lo, cmd, LOC_KEY1, CMD_WIPE)) nxt = ST_W1;
        end
        ST_PGM_ARG: pgm_hit = 1'b1;
        ST_W1: if (key1_now) nxt = ST_W2;
        ST_W2: if (step_match(addr_lo, cmd, LOC_KEY2, CMD_KEY2)) nxt = ST_W3;
        ST_W3: begin
          if (cmd == CMD_SECTOR) begin
            ers_hit = 1'b1; hit_kind = EK_SECT;
          end else if (cmd == CMD_BLOCK) begin
            ers_hit = 1'b1; hit_kind = EK_BLK;
          end else if (step_match(addr_lo, cmd, LOC_KEY1, CMD_CHIP)) begin
            ers_hit = 1'b1; hit_kind = EK_CHIP;
          end
        end
        default: nxt = ST_READ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= ST_READ;
      wp_lock <= 1'b0;
    end else begin
      state <= nxt;
      if (wr_evt && state == ST_READ && key1_now) wp_lock <= ~wp_n;
    end
  end
endmodule

// File: rtl/fsc_erase_track.sv
module fsc_erase_track (
  input  logic clk,
  input  logic rst_n,
  input  logic ers_go,
  input  logic susp_go,
  input  logic res_go,
  input  logic erase_done,
  output logic active,
  output logic suspended
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active    <= 1'b0;
      suspended <= 1'b0;
    end else if (ers_go) begin
      active    <= 1'b1;
      suspended <= 1'b0;
    end else if (erase_done) begin
      active    <= 1'b0;
      suspended <= 1'b0;
    end else if (susp_go) begin
      suspended <= 1'b1;
    end else if (res_go) begin
      suspended <= 1'b0;
    end
  end
endmodule

// File: rtl/flash_cmd_decoder.sv
module flash_cmd_decoder
  import flash_cmd_pkg::*;
#(
  parameter int ADDR_W      = 20,
  parameter int DATA_W      = 16,
  parameter int SYNC_STAGES = 2,
  parameter int SECT_W      = 11,
  parameter int BLK_W       = 15,
  parameter int PROT_W      = 13
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we_n,
  input  logic              ce_n,
  input  logic              oe_n,
  input  logic              wp_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              erase_done,
  output logic              pgm_req,
  output logic [ADDR_W-1:0] pgm_addr,
  output logic [DATA_W-1:0] pgm_data,
  output logic              ers_req,
  output logic [1:0]        ers_kind,
  output logic [ADDR_W-1:0] ers_addr,
  output logic              susp_req,
  output logic              resume_req,
  output logic              erase_active,
  output logic              erase_suspended
);
  localparam logic [ADDR_W-1:0] SECT_MASK = {ADDR_W{1'b1}} << SECT_W;
  localparam logic [ADDR_W-1:0] BLK_MASK  = {ADDR_W{1'b1}} << BLK_W;

  logic   wr_evt, pgm_hit, ers_hit, susp_hit, res_hit, wp_lock;
  ekind_t hit_kind;
  logic   pgm_ok, ers_ok, susp_ok, res_ok;

  // EK_NONE stands for a single-word program
  function automatic logic in_guard(input ekind_t k, input logic [ADDR_W-1:0] a);
    case (k)
      EK_BLK:  return &a[ADDR_W-1:BLK_W];
      EK_CHIP: return 1'b1;
      default: return &a[ADDR_W-1:PROT_W];
    endcase
  endfunction

  function automatic logic [ADDR_W-1:0] erase_base(input ekind_t k, input logic [ADDR_W-1:0] a);
    case (k)
      EK_SECT: return a & SECT_MASK;
      EK_BLK:  return a & BLK_MASK;
      default: return '0;
    endcase
  endfunction

  fsc_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .we_n(we_n), .ce_n(ce_n), .oe_n(oe_n), .wr_evt(wr_evt)
  );

  fsc_seq u_seq (
    .clk(clk), .rst_n(rst_n), .wr_evt(wr_evt), .addr_lo(addr[14:0]), .cmd(wdata[7:0]),
    .wp_n(wp_n), .pgm_hit(pgm_hit), .ers_hit(ers_hit), .hit_kind(hit_kind),
    .susp_hit(susp_hit), .res_hit(res_hit), .wp_lock(wp_lock)
  );

  fsc_erase_track u_trk (
    .clk(clk), .rst_n(rst_n), .ers_go(ers_ok), .susp_go(susp_ok), .res_go(res_ok),
    .erase_done(erase_done), .active(erase_active), .suspended(erase_suspended)
  );

  always_comb begin
    pgm_ok  = pgm_hit && (!erase_active || erase_suspended)
              && !(wp_lock && in_guard(EK_NONE, addr));
    ers_ok  = ers_hit && !erase_active && !(wp_lock && in_guard(hit_kind, addr));
    susp_ok = susp_hit && erase_active && !erase_suspended;
    res_ok  = res_hit && erase_suspended;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pgm_req    <= 1'b0;
      ers_req    <= 1'b0;
      susp_req   <= 1'b0;
      resume_req <= 1'b0;
      pgm_addr   <= '0;
      pgm_data   <= '0;
      ers_kind   <= 2'd0;
      ers_addr   <= '0;
    end else begin
      pgm_req    <= pgm_ok;
      ers_req    <= ers_ok;
      susp_req   <= susp_ok;
      resume_req <= res_ok;
      if (pgm_ok) begin
        pgm_addr <= addr;
        pgm_data <= wdata;
      end
      if (ers_ok) begin
        ers_kind <= hit_kind;
        ers_addr <= erase_base(hit_kind, addr);
      end
    end
  end
endmodule

// File: rtl/flash_cmd_decoder_chk.sv
module flash_cmd_decoder_chk #(
  parameter int ADDR_W = 20,
  parameter int PROT_W = 13
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_evt,
  input logic              wp_lock,
  input logic              pgm_req,
  input logic [ADDR_W-1:0] pgm_addr,
  input logic              ers_req,
  input logic [1:0]        ers_kind,
  input logic              susp_req,
  input logic              resume_req,
  input logic              erase_active,
  input logic              erase_suspended
);
  a_r5_req_after_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    (pgm_req || ers_req || susp_req || resume_req) |-> $past(wr_evt));

  a_r10_one_req: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({pgm_req, ers_req, susp_req, resume_req}));

  a_r10_pgm_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    pgm_req |=> !pgm_req);

  a_r4_guard_pgm: assert property (@(posedge clk) disable iff (!rst_n)
    (pgm_req && $past(wp_lock)) |-> !(&pgm_addr[ADDR_W-1:PROT_W]));

  a_r4_guard_chip: assert property (@(posedge clk) disable iff (!rst_n)
    (ers_req && ers_kind == 2'd3) |-> !$past(wp_lock));

  a_r8_no_stack: assert property (@(posedge clk) disable iff (!rst_n)
    ers_req |-> !$past(erase_active));

  a_r7_suspend_when_running: assert property (@(posedge clk) disable iff (!rst_n)
    susp_req |-> $past(erase_active && !erase_suspended));

  a_r7_resume_when_parked: assert property (@(posedge clk) disable iff (!rst_n)
    resume_req |-> $past(erase_suspended));
endmodule

bind flash_cmd_decoder flash_cmd_decoder_chk #(.ADDR_W(ADDR_W), .PROT_W(PROT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_evt(wr_evt), .wp_lock(wp_lock),
  .pgm_req(pgm_req), .pgm_addr(pgm_addr), .ers_req(ers_req), .ers_kind(ers_kind),
  .susp_req(susp_req), .resume_req(resume_req),
  .erase_active(erase_active), .erase_suspended(erase_suspended)
);

// File: tb/flash_cmd_decoder_test.sv
`timescale 1ns/1ps
module flash_cmd_decoder_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        we_n = 1'b1, ce_n = 1'b1, oe_n = 1'b1, wp_n = 1'b1;
  logic [19:0] addr = '0;
  logic [15:0] wdata = '0;
  logic        erase_done = 1'b0;
  logic        pgm_req, ers_req, susp_req, resume_req, erase_active, erase_suspended;
  logic [19:0] pgm_addr, ers_addr;
  logic [15:0] pgm_data;
  logic [1:0]  ers_kind;

  int n_chk = 0, n_fail = 0;
  int ev_cnt = 0, last_ev = 0, bad_multi = 0, bad_len = 0;
  logic [19:0] last_pa, last_ea;
  logic [15:0] last_pd;
  logic        prev_pgm = 1'b0, prev_ers = 1'b0;

  always #2.5 clk = ~clk;

  flash_cmd_decoder uut (
    .clk(clk), .rst_n(rst_n), .we_n(we_n), .ce_n(ce_n), .oe_n(oe_n), .wp_n(wp_n),
    .addr(addr), .wdata(wdata), .erase_done(erase_done),
    .pgm_req(pgm_req), .pgm_addr(pgm_addr), .pgm_data(pgm_data),
    .ers_req(ers_req), .ers_kind(ers_kind), .ers_addr(ers_addr),
    .susp_req(susp_req), .resume_req(resume_req),
    .erase_active(erase_active), .erase_suspended(erase_suspended)
  );

  // event codes: 0 none, 1 program, 2 sector, 3 block, 4 chip, 5 suspend, 6 resume
  always @(negedge clk) begin
    if (rst_n) begin
      if (int'(pgm_req) + int'(ers_req) + int'(susp_req) + int'(resume_req) > 1) bad_multi++;
      if ((pgm_req && prev_pgm) || (ers_req && prev_ers)) bad_len++;
      if (pgm_req)    begin ev_cnt++; last_ev = 1; last_pa = pgm_addr; last_pd = pgm_data; end
      if (ers_req)    begin ev_cnt++; last_ev = 1 + int'(ers_kind); last_ea = ers_addr; end
      if (susp_req)   begin ev_cnt++; last_ev = 5; end
      if (resume_req) begin ev_cnt++; last_ev = 6; end
    end
    prev_pgm = pgm_req;
    prev_ers = ers_req;
  end

  function automatic int got_ev();
    if (ev_cnt == 0) return 0;
    if (ev_cnt > 1) return 7;
    return last_ev;
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [19:0] a, input logic [15:0] d,
                    input bit ce = 1'b0, input bit oe = 1'b1, input int low = 3);
    ev_cnt = 0;
    @(negedge clk); addr = a; wdata = d; ce_n = ce; oe_n = oe;
    @(negedge clk); we_n = 1'b0;
    repeat (low) @(negedge clk);
    we_n = 1'b1;
    repeat (4) @(negedge clk);
    ce_n = 1'b1; oe_n = 1'b1;
  endtask

  task automatic prog(input logic [19:0] a, input logic [15:0] d);
    wr(20'h05555, 16'h00AA); wr(20'h02AAA, 16'h0055); wr(20'h05555, 16'h00A0); wr(a, d);
  endtask

  task automatic wipe(input logic [7:0] c, input logic [19:0] a);
    wr(20'h05555, 16'h00AA); wr(20'h02AAA, 16'h0055); wr(20'h05555, 16'h0080);
    wr(20'h05555, 16'h00AA); wr(20'h02AAA, 16'h0055); wr(a, {8'h00, c});
  endtask

  task automatic finish_erase();
    @(negedge clk); erase_done = 1'b1;
    @(negedge clk); erase_done = 1'b0;
    @(negedge clk);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  // vector: {ce_n, oe_n, done, addr[19:0], data[15:0], expected event[2:0]}
  localparam int NV = 50;
  localparam logic [41:0] VEC [NV] = '{
    {1'b0,1'b1,1'b0,20'h05555,16'h00AA,3'd0}, {1'b0,1'b1,1'b0,20'h02AAA,16'h0055,3'd0},
    {1'b0,1'b1,1'b0,20'h05555,16'h00A0,3'd0}, {1'b0,1'b1,1'b0,20'h01234,16'h1234,3'd1},
    {1'b0,1'b1,1'b0,20'h05555,16'h00AA,3'd0}, {1'b0,1'b1,1'b0,20'h02AAA,16'h0055,3'd0},
    {1'b0,1'b1,1'b0,20'h05555,16'h0080,3'd0}, {1'b0,1'b1,1'b0,20'h05555,16'h00AA,3'd0},
    {1'b0,1'b1,1'b0,20'h02AAA,16'h0055,3'd0}, {1'b0,1'b1,1'b0,20'h12345,16'h0030,3'd2},
    {1'b0,1'b1,1'b0,20'h00000,16'h00B0,3'd5}, {1'b0,1'b1,1'b1,20'h00000,16'h0030,3'd6},
    {1'b0,1'b1,1'b0,20'h05555,16'h00AA,3'd0}, {1'b0,1'b1,1'b0,20'h02AAA,16'h0055,3'd0},
    {1'b0,1'b1,1'b0,20'h05555,16'h0055,3'd0}, {1'b0,1'b1,1'b0,20'h05555,16'h00A0,3'd0},
    {1'b0,1'b1,1'b0,20'h00100,16'h9999,3'd0}, {1'b0,1'b1,1'b0,20'hF5555,16'h00AA,3'd0},
    {1'b0,1'b1,1'b0,20'h72AAA,16'h0055,3'd0}, {1'b0,1'b1,1'b0,20'h15555,16'h00A0,3'd0},
    {1'b0,1'b1,1'b0,20'h00ABC,16'hBEEF,3'd1}, {1'b0,1'b1,1'b0,20'h05555,16'h00AA,3'd0},
    {1'b1,1'b1,1'b0,20'h02AAA,16'h0055,3'd0}, {1'b0,1'b1,1'b0,20'h02AAA,16'h0055,3'd0},
    {1'b0,1'b1,1'b0,20'h05555,16'h00A0,3'd0}, {1'b0,1'b1,1'b0,20'h00044,16'h4444,3'd1},
    {1'b0,1'b1,1'b0,20'h05555,16'h00AA,3'd0}, {1'b0,1'b1,1'b0,20'h02AAA,16'h0055,3'd0},
    {1'b0,1'b0,1'b0,20'h05555,16'h00A0,3'd0}, {1'b0,1'b1,1'b0,20'h05555,16'h00A0,3'd0},
    {1'b0,1'b1,1'b0,20'h00055,16'h5555,3'd1}, {1'b0,1'b1,1'b0,20'h05555,16'h00AA,3'd0},
    {1'b0,1'b1,1'b0,20'h02AAA,16'h0055,3'd0}, {1'b0,1'b1,1'b0,20'h05555,16'h0080,3'd0},
    {1'b0,1'b1,1'b0,20'h05555,16'h00AA,3'd0}, {1'b0,1'b1,1'b0,20'h02AAA,16'h0055,3'd0},
    {1'b0,1'b1,1'b1,20'hABCDE,16'h0050,3'd3}, {1'b0,1'b1,1'b0,20'h05555,16'h00AA,3'd0},
    {1'b0,1'b1,1'b0,20'h02AAA,16'h0055,3'd0}, {1'b0,1'b1,1'b0,20'h05555,16'h0080,3'd0},
    {1'b0,1'b1,1'b0,20'h05555,16'h00AA,3'd0}, {1'b0,1'b1,1'b0,20'h02AAA,16'h0055,3'd0},
    {1'b0,1'b1,1'b1,20'h05555,16'h0010,3'd4}, {1'b0,1'b1,1'b0,20'h05555,16'h00AA,3'd0},
    {1'b0,1'b1,1'b0,20'h02AAA,16'h0055,3'd0}, {1'b0,1'b1,1'b0,20'h05555,16'h0080,3'd0},
    {1'b0,1'b1,1'b0,20'h05555,16'h00AA,3'd0}, {1'b0,1'b1,1'b0,20'h02AAA,16'h0055,3'd0},
    {1'b0,1'b1,1'b0,20'h01000,16'h0020,3'd0}, {1'b0,1'b1,1'b0,20'h00000,16'h0030,3'd0}
  };

  initial begin
    #(200000 * 5);
    n_fail++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R6: reset state
    chk(!pgm_req && !ers_req && !susp_req && !resume_req, "R6 reset requests", {pgm_req, ers_req, susp_req, resume_req}, 0);
    chk(!erase_active && !erase_suspended, "R6 reset erase flags", {erase_active, erase_suspended}, 0);
    do_reset();

    for (int i = 0; i < NV; i++) begin
      logic [19:0] va;
      logic [15:0] vd;
      int          ve;
      logic [19:0] ea;
      va = VEC[i][38:19];
      vd = VEC[i][18:3];
      ve = int'(VEC[i][2:0]);
      wr(va, vd, VEC[i][41], VEC[i][40]);
      // R1 program, R2 erase, R3 abort, R5 inhibit, R7 suspend/resume, R11 upper bits
      chk(got_ev() == ve, $sformatf("R1/R2/R3/R5/R7/R11 vector %0d event", i), got_ev(), ve);
      if (ve == 1) begin
        chk(last_pa == va && last_pd == vd, $sformatf("R1 vector %0d addr/data", i), {last_pa, last_pd}, {va, vd});
      end
      if (ve >= 2 && ve <= 4) begin
        ea = (ve == 2) ? {va[19:11], 11'd0} : (ve == 3) ? {va[19:15], 15'd0} : 20'd0;
        chk(last_ea == ea, $sformatf("R2 vector %0d erase base", i), last_ea, ea);
        chk(erase_active, "R2 erase active", erase_active, 1);
      end
      if (VEC[i][39]) begin
        finish_erase();
        chk(!erase_active, "R9 erase_done clears", erase_active, 0);
      end
    end

    // R4 protect pin
    wp_n = 1'b0;
    prog(20'hFFFF0, 16'h1111); chk(got_ev() == 0, "R4 guarded program refused", got_ev(), 0);
    prog(20'h00010, 16'h2222); chk(got_ev() == 1, "R4 unguarded program granted", got_ev(), 1);
    wipe(8'h30, 20'hFE000);    chk(got_ev() == 0, "R4 guarded sector refused", got_ev(), 0);
    wipe(8'h50, 20'hF9000);    chk(got_ev() == 0, "R4 guarded block refused", got_ev(), 0);
    wipe(8'h10, 20'h05555);    chk(got_ev() == 0, "R4 chip erase refused", got_ev(), 0);
    chk(!erase_active, "R4 no erase started", erase_active, 0);
    wr(20'h05555, 16'h00AA); wp_n = 1'b1;
    wr(20'h02AAA, 16'h0055); wr(20'h05555, 16'h00A0); wr(20'hFFFF0, 16'h3333);
    chk(got_ev() == 0, "R4 late release ignored", got_ev(), 0);
    wr(20'h05555, 16'h00AA); wp_n = 1'b0;
    wr(20'h02AAA, 16'h0055); wr(20'h05555, 16'h00A0); wr(20'hFFFF0, 16'h4444);
    chk(got_ev() == 1, "R4 late assert ignored", got_ev(), 1);
    wp_n = 1'b1;

    // R8 busy erase, R7 suspend rules
    wipe(8'h30, 20'h00800);     chk(got_ev() == 2, "R8 erase started", got_ev(), 2);
    prog(20'h00020, 16'h5555);  chk(got_ev() == 0, "R8 program while erasing", got_ev(), 0);
    wipe(8'h30, 20'h01000);     chk(got_ev() == 0, "R8 erase while erasing", got_ev(), 0);
    wr(20'h00000, 16'h00B0);    chk(got_ev() == 5, "R7 suspend", got_ev(), 5);
    chk(erase_suspended, "R7 suspended flag", erase_suspended, 1);
    prog(20'h00020, 16'h6666);  chk(got_ev() == 1, "R8 program while suspended", got_ev(), 1);
    wipe(8'h50, 20'h08000);     chk(got_ev() == 0, "R8 erase while suspended", got_ev(), 0);
    wr(20'h00000, 16'h00B0);    chk(got_ev() == 0, "R7 second suspend ignored", got_ev(), 0);
    wr(20'h00000, 16'h0030);    chk(got_ev() == 6, "R7 resume", got_ev(), 6);
    chk(!erase_suspended, "R7 resumed flag", erase_suspended, 0);
    finish_erase();
    chk(!erase_active, "R9 done clears active", erase_active, 0);

    // R6 reset during erase and mid-sequence
    wipe(8'h30, 20'h00000);     chk(got_ev() == 2, "R6 erase started", got_ev(), 2);
    wr(20'h00000, 16'h00B0);    chk(got_ev() == 5, "R6 suspended", got_ev(), 5);
    do_reset();
    chk(!erase_active && !erase_suspended, "R6 reset clears erase", {erase_active, erase_suspended}, 0);
    wr(20'h00000, 16'h0030);    chk(got_ev() == 0, "R6 no resume after reset", got_ev(), 0);
    wr(20'h05555, 16'h00AA); wr(20'h02AAA, 16'h0055);
    do_reset();
    wr(20'h05555, 16'h00A0); wr(20'h00300, 16'h7777);
    chk(got_ev() == 0, "R6 sequence cleared", got_ev(), 0);

    // R5 stretched strobe counts once
    wr(20'h05555, 16'h00AA, 1'b0, 1'b1, 20);
    wr(20'h02AAA, 16'h0055); wr(20'h05555, 16'h00A0); wr(20'h00400, 16'h8888);
    chk(got_ev() == 1, "R5 long strobe single write", got_ev(), 1);

    // R10 exclusivity and pulse width
    chk(bad_multi == 0, "R10 one request per cycle", bad_multi, 0);
    chk(bad_len == 0, "R10 one-cycle pulses", bad_len, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule